// File: doc/BRIEF.md
# Flash Operation Status Reporter

This block builds the status byte that an embedded flash controller places on the read data path while a program or erase job is running, and after it has ended. The internal program/erase sequencer supplies a busy level. Separate event strobes report four conditions: the retry pulse budget ran out, a write tried to raise a cleared bit, the target region is protected, and the programming supply was too low during a job. The read path supplies a strobe for each status read. The command decoder supplies a single exit strobe.

The byte has four defined fields. The top bit is a completion flag whose sense is chosen by a two-bit configuration input. Bit 6 flips on each read while a job runs. Bit 5 is a sticky failure flag and bit 3 is a sticky supply flag. Software polls the byte until the job ends, then inspects the two error flags. An error that has been latched stays visible until the exit command is seen. A ready/busy line is modelled as an open-drain pin, with a drive-enable and a fixed low data value, so several devices can share one wire.

Top module: `fsr_status_top`

## Requirements
- R1: With `poll_cfg` = 2'b01, status bit 7 reads 0 while a job is running and 1 while idle. Each change appears one clock after `op_busy` changes.
- R2: With `poll_cfg` = 2'b10, bit 7 reads 1 while a job is running and 0 while idle. With `poll_cfg` = 2'b00 or 2'b11, bit 7 reads 0 at all times.
- R3: While a job is running, every cycle with `rd_stb` high inverts status bit 6. The new value is visible from the following cycle.
- R4: While idle, read strobes leave bit 6 unchanged. When a new job starts (`op_busy` rises), bit 6 returns to 0 in that cycle, even if a read strobe arrives in the same cycle.
- R5: A strobe on `pulse_ovf`, `one_over_zero` or `prot_hit` latches the failure flag reported on bit 5.
- R6: Bit 5 reads 0 while a job is running, even when the failure flag is latched.
- R7: `vpp_low` high while `op_busy` is high latches the supply flag on bit 3. `vpp_low` while idle has no effect.
- R8: The failure and supply flags stay latched until a cycle with `exit_cmd` high. If a set condition occurs in the same cycle as `exit_cmd`, the flag stays set.
- R9: `rb_oe` is high (the line is pulled low) from one clock after `op_busy` rises until one clock after it falls. `rb_data` is always 0.
- R10: Status bits 4, 2, 1 and 0 always read 0.
- R11: After reset the block is idle, bit 6 and both latched flags are 0, and `rb_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_cfg | input | 2 | Completion-bit polarity select |
| op_busy | input | 1 | Sequencer job-active level |
| rd_stb | input | 1 | One strobe per status read |
| pulse_ovf | input | 1 | Retry pulse budget exceeded |
| one_over_zero | input | 1 | Write attempted to raise a cleared bit |
| prot_hit | input | 1 | Job aimed at a protected region |
| vpp_low | input | 1 | Programming supply too low |
| exit_cmd | input | 1 | Decoded exit command strobe |
| status | output | 8 | Status byte |
| rb_oe | output | 1 | Ready/busy drive enable |
| rb_data | output | 1 | Ready/busy driven value, fixed 0 |

## Verification
The bench goes after the corner cases where a simple design gets the order of conditions wrong. A read strobe that lands on the first cycle of a new job must leave bit 6 at 0; a design that gives the read priority would start the toggle sequence at 1. When a failure arrives in the same cycle as the exit command, the failure must stay latched; a design that gives the clear priority would lose the error. A failure latched during a job must stay hidden on bit 5 until the job ends and then appear; a design that does not mask it would show the error too early, and a design that masks it by clearing the flag would lose it. A low supply seen while idle must leave bit 3 clear; a design that does not qualify the flag with the busy level would latch a false error.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int STAT_W = 8;
  localparam int B_DONE = 7;
  localparam int B_TGL  = 6;
  localparam int B_ERR  = 5;
  localparam int B_VPP  = 3;

  typedef enum logic [1:0] {
    POLL_OFF_A     = 2'b00,
    POLL_LOW_BUSY  = 2'b01,
    POLL_HIGH_BUSY = 2'b10,
    POLL_OFF_B     = 2'b11
  } poll_cfg_e;

  function automatic logic bit_defined(input int idx);
    return (idx == B_DONE) || (idx == B_TGL) || (idx == B_ERR) || (idx == B_VPP);
  endfunction
endpackage

// File: rtl/fsr_rst_sync.sv
module fsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fsr_track.sv
module fsr_track (
  input  logic clk,
  input  logic rst_n,
  input  logic op_busy,
  output logic busy_q,
  output logic start,
  output logic rb_oe,
  output logic rb_data
);
  logic busy_d;

  always_comb begin
    busy_d = op_busy;
    start  = op_busy & ~busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign rb_oe   = busy_q;
  assign rb_data = 1'b0;

  p_rb_assert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy |=> rb_oe);
  p_rb_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_busy |=> !rb_oe);
endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_q,
  input  logic start,
  input  logic rd_stb,
  output logic tgl_q
);
  logic tgl_d;
  logic tgl_en;

  always_comb begin
    tgl_en = start | (busy_q & rd_stb);
    tgl_d  = start ? 1'b0 : ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgl_q <= 1'b0;
    else if (tgl_en) tgl_q <= tgl_d;
  end

  p_tgl_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_stb && !start) |=> (tgl_q != $past(tgl_q)));
  p_tgl_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(tgl_q));
  p_tgl_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !tgl_q);
endmodule

// File: rtl/fsr_sticky.sv
module fsr_sticky #(
  parameter int N_SRC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_vec,
  input  logic             clr,
  output logic             flag_q
);
  logic any_set;
  logic flag_d;
  logic flag_en;

  always_comb begin
    any_set = |set_vec;
    flag_en = any_set | clr;
    flag_d  = any_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  p_sticky_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> flag_q);
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/fsr_compose.sv
module fsr_compose
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        poll_cfg,
  input  logic              busy_q,
  input  logic              tgl_q,
  input  logic              err_q,
  input  logic              vpp_q,
  output logic [STAT_W-1:0] status
);
  logic done_bit;

  always_comb begin
    case (poll_cfg)
      POLL_LOW_BUSY:  done_bit = ~busy_q;
      POLL_HIGH_BUSY: done_bit =  busy_q;
      default:        done_bit = 1'b0;
    endcase
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == B_DONE) begin : g_done
      assign status[i] = done_bit;
    end else if (i == B_TGL) begin : g_tgl
      assign status[i] = tgl_q;
    end else if (i == B_ERR) begin : g_err
      assign status[i] = err_q & ~busy_q;
    end else if (i == B_VPP) begin : g_vpp
      assign status[i] = vpp_q;
    end else begin : g_zero
      assign status[i] = 1'b0;
    end
  end

  p_err_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !status[B_ERR]);
  p_done_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_cfg == 2'b01 && busy_q) |-> !status[B_DONE]);
  p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !status[4] && !status[2] && !status[1] && !status[0]);
endmodule

// File: rtl/fsr_status_top.sv
module fsr_status_top
  import fsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        poll_cfg,
  input  logic              op_busy,
  input  logic              rd_stb,
  input  logic              pulse_ovf,
  input  logic              one_over_zero,
  input  logic              prot_hit,
  input  logic              vpp_low,
  input  logic              exit_cmd,
  output logic [STAT_W-1:0] status,
  output logic              rb_oe,
  output logic              rb_data
);
  localparam int N_ERR_SRC = 3;

  logic                 rst_int_n;
  logic                 busy_q;
  logic                 start;
  logic                 tgl_q;
  logic                 err_q;
  logic                 vpp_q;
  logic [N_ERR_SRC-1:0] err_set;
  logic [0:0]           vpp_set;

  assign err_set = {pulse_ovf, one_over_zero, prot_hit};
  assign vpp_set = vpp_low & op_busy;

  fsr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  fsr_track u_track (
    .clk(clk), .rst_n(rst_int_n), .op_busy(op_busy),
    .busy_q(busy_q), .start(start), .rb_oe(rb_oe), .rb_data(rb_data)
  );

  fsr_toggle u_toggle (
    .clk(clk), .rst_n(rst_int_n), .busy_q(busy_q), .start(start),
    .rd_stb(rd_stb), .tgl_q(tgl_q)
  );

  fsr_sticky #(.N_SRC(N_ERR_SRC)) u_err (
    .clk(clk), .rst_n(rst_int_n), .set_vec(err_set), .clr(exit_cmd),
    .flag_q(err_q)
  );

  fsr_sticky #(.N_SRC(1)) u_vpp (
    .clk(clk), .rst_n(rst_int_n), .set_vec(vpp_set), .clr(exit_cmd),
    .flag_q(vpp_q)
  );

  fsr_compose u_compose (
    .clk(clk), .rst_n(rst_int_n), .poll_cfg(poll_cfg), .busy_q(busy_q),
    .tgl_q(tgl_q), .err_q(err_q), .vpp_q(vpp_q), .status(status)
  );

  p_idle_vpp_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!op_busy && !exit_cmd && !vpp_q) |=> !vpp_q);
endmodule

// File: tb/tb_fsr_status_top.sv
module tb_fsr_status_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] st;
    logic       oe;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] poll_cfg = 2'b01;
  logic       op_busy = 1'b0, rd_stb = 1'b0, pulse_ovf = 1'b0;
  logic       one_over_zero = 1'b0, prot_hit = 1'b0, vpp_low = 1'b0, exit_cmd = 1'b0;
  logic [7:0] status;
  logic       rb_oe, rb_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t sb[$];

  logic m_busy = 1'b0, m_tgl = 1'b0, m_e5 = 1'b0, m_e3 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsr_status_top dut (
    .clk(clk), .rst_n(rst_n), .poll_cfg(poll_cfg), .op_busy(op_busy),
    .rd_stb(rd_stb), .pulse_ovf(pulse_ovf), .one_over_zero(one_over_zero),
    .prot_hit(prot_hit), .vpp_low(vpp_low), .exit_cmd(exit_cmd),
    .status(status), .rb_oe(rb_oe), .rb_data(rb_data)
  );

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard.
  task automatic cyc(input logic [1:0] cfg, input logic bz, input logic rd,
                     input logic ovf, input logic o0z, input logic pr,
                     input logic vl, input logic ex, input string tag);
    exp_t e;
    logic b7;
    @(negedge clk);
    poll_cfg = cfg; op_busy = bz; rd_stb = rd; pulse_ovf = ovf;
    one_over_zero = o0z; prot_hit = pr; vpp_low = vl; exit_cmd = ex;
    if (bz && !m_busy)   m_tgl = 1'b0;
    else if (m_busy && rd) m_tgl = ~m_tgl;
    if (ovf || o0z || pr) m_e5 = 1'b1; else if (ex) m_e5 = 1'b0;
    if (bz && vl)         m_e3 = 1'b1; else if (ex) m_e3 = 1'b0;
    m_busy = bz;
    case (cfg)
      2'b01:   b7 = ~m_busy;
      2'b10:   b7 =  m_busy;
      default: b7 = 1'b0;
    endcase
    e.st  = {b7, m_tgl, m_e5 & ~m_busy, 1'b0, m_e3, 3'b000};
    e.oe  = m_busy;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares shortly after each active edge.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (status !== e.st || rb_oe !== e.oe || rb_data !== 1'b0) begin
        fails++;
        $display("FAIL %s: status=%h oe=%b data=%b expected status=%h oe=%b data=0",
                 e.tag, status, rb_oe, rb_data, e.st, e.oe);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cyc(2'b01, 0,0,0,0,0,0,0, "R11 reset state");
    cyc(2'b01, 0,1,0,0,0,0,0, "R4 idle read no toggle");
    cyc(2'b01, 1,0,0,0,0,0,0, "R1 R9 job start");
    cyc(2'b01, 1,1,0,0,0,0,0, "R3 toggle 1");
    cyc(2'b01, 1,1,0,0,0,0,0, "R3 toggle 2");
    cyc(2'b01, 1,1,0,0,0,0,0, "R3 toggle 3");
    cyc(2'b01, 1,0,0,0,0,0,0, "R3 hold without read");
    cyc(2'b01, 0,0,0,0,0,0,0, "R1 R9 job end");
    cyc(2'b01, 0,1,0,0,0,0,0, "R4 idle read holds");
    cyc(2'b01, 1,1,0,0,0,0,0, "R4 start with read clears");
    cyc(2'b01, 1,1,0,0,0,0,0, "R3 toggle after restart");
    cyc(2'b01, 0,0,0,0,0,0,0, "R1 end");
    cyc(2'b01, 0,0,0,0,0,1,0, "R7 idle vpp ignored");
    cyc(2'b01, 1,0,0,0,0,1,0, "R7 vpp latch in job");
    cyc(2'b01, 0,0,0,0,0,0,0, "R8 vpp kept after job");
    cyc(2'b01, 0,0,0,0,0,0,0, "R8 vpp still kept");
    cyc(2'b01, 0,0,0,0,0,0,1, "R8 exit clears vpp");
    cyc(2'b01, 1,0,1,0,0,0,0, "R6 overflow hidden in job");
    cyc(2'b01, 1,0,0,0,0,0,0, "R6 still hidden");
    cyc(2'b01, 0,0,0,0,0,0,0, "R5 overflow visible idle");
    cyc(2'b01, 0,0,0,0,0,0,1, "R8 exit clears err");
    cyc(2'b01, 0,0,0,1,0,0,0, "R5 one over zero");
    cyc(2'b01, 0,0,0,0,1,0,1, "R8 set beats exit");
    cyc(2'b01, 0,0,0,0,0,0,1, "R8 exit clears");
    cyc(2'b01, 0,0,0,0,1,0,0, "R5 protected target");
    cyc(2'b01, 0,0,0,0,0,0,1, "R8 exit after prot");
    cyc(2'b10, 0,0,0,0,0,0,0, "R2 cfg10 idle");
    cyc(2'b10, 1,0,0,0,0,0,0, "R2 cfg10 busy");
    cyc(2'b00, 1,0,0,0,0,0,0, "R2 cfg00 busy");
    cyc(2'b11, 0,0,0,0,0,0,0, "R2 cfg11 idle");
    cyc(2'b00, 0,1,1,1,1,1,0, "R10 undefined bits zero");
    cyc(2'b01, 0,0,0,0,0,0,1, "R10 R8 final exit");
    @(posedge clk); #4;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule